// File: doc/BRIEF.md
# Request-Gated Block DMA Sequencer

This block moves words between a memory port and a device port in blocks of a programmed size. A channel configuration holds a 24-bit base address, a 16-bit block size, a 16-bit block count, a direction bit, an address-step bit, an enable bit and a start flag. While the channel is enabled and holds blocks, a high device request at a block boundary lets one more block through. One word moves per clock. For each word the running address steps by four, upward or downward.

When the request is low at a block boundary, or when the count runs out, the sequencer stops. It then stores the address that follows the last word as the new base and keeps the remaining count. A later request resumes the channel from that stored state. Once the count is exhausted, the sequencer pulses a completion strobe and drops the enable.

Memory accesses see only the word-aligned low part of the running address, so a reverse walk below zero wraps within the memory window. The stored base keeps 24 bits of the running value.

Top module: `blk_dma_seq`

## Requirements
- R1: After reset the channel is idle: busy, done, enable and start flag are 0, the stored base and count are 0, and no memory or device strobe is active.
- R2: A configuration load is accepted only while idle. A load presented while busy has no effect on the running transfer or on the stored base and count.
- R3: A transfer begins only when the channel is enabled, the count is nonzero and the request is high while idle. The start flag reads 0 from the cycle the transfer begins.
- R4: One word moves per busy cycle. With direction 0, memory is read and the word is written to the device. With direction 1, the device is read and the word is written to memory. Memory read and memory write are never active together.
- R5: The running address starts at the base and changes by +4 per word, or by -4 when the step bit is 1. It carries on across block boundaries. Each memory address is the running address ANDed with 0x001FFFFC.
- R6: The count drops by one as each block starts. The request is sampled only in the last word of a block. The next block follows at once if the request is high and the count is nonzero.
- R7: When it stops, the sequencer stores the address after the last word, ANDed with 0x00FFFFFF, as the base, and keeps the remaining count.
- R8: If the sequencer stops with a nonzero count, the channel stays enabled. The next request resumes from the stored base and count.
- R9: A stop with the count at zero gives a one-cycle done pulse and clears enable. An enabled channel loaded with count 0 does the same without any access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load the configuration fields below |
| cfg_base | input | 24 | Base address to load |
| cfg_blk_size | input | 16 | Words per block |
| cfg_blk_count | input | 16 | Number of blocks |
| cfg_to_mem | input | 1 | Direction: 0 memory to device, 1 device to memory |
| cfg_step_down | input | 1 | Address step: 0 is +4, 1 is -4 |
| cfg_enable | input | 1 | Channel enable value to load |
| cfg_trigger | input | 1 | Start flag value to load |
| dev_req | input | 1 | Device request, sampled at block boundaries |
| mem_addr | output | 32 | Masked word address of the current access |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Data written to memory |
| mem_rdata | input | 32 | Data read from memory, same cycle |
| dev_rd | output | 1 | Device read strobe |
| dev_rdata | input | 32 | Data from the device, same cycle |
| dev_wr | output | 1 | Device write strobe |
| dev_wdata | output | 32 | Data written to the device |
| st_base | output | 24 | Stored base address |
| st_count | output | 16 | Remaining block count |
| st_enable | output | 1 | Channel enable |
| st_trigger | output | 1 | Start flag |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong running address shows up on the first memory access after it goes wrong, since every access carries it through the mask. It shows up again in the stored base once the transfer stops. A wrong count or a wrong boundary decision changes the number of words moved. That is visible when busy falls, at most one block after the fault. The bench also sees it through the stored count, the enable and the done pulse. A fault in the direction routing corrupts data on the first word, and the bench compares each word with its own memory and device models.

// File: rtl/blk_dma_pkg.sv
package blk_dma_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_XFER = 1'b1
    } phase_e;
endpackage

// File: rtl/blk_dma_addr.sv
module blk_dma_addr #(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] MEM_MASK = 32'h001F_FFFC
) (
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic              step_down_i,
    output logic [ADDR_W-1:0] ptr_next_o,
    output logic [ADDR_W-1:0] mem_addr_o
);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

    always_comb begin
        ptr_next_o = step_down_i ? (ptr_i - WORD_STEP) : (ptr_i + WORD_STEP);
        mem_addr_o = ptr_i & MEM_MASK;
    end
endmodule

// File: rtl/blk_dma_route.sv
module blk_dma_route #(
    parameter int DATA_W = 32
) (
    input  logic              active_i,
    input  logic              to_mem_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic [DATA_W-1:0] dev_rdata_i,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              dev_rd_o,
    output logic              dev_wr_o,
    output logic [DATA_W-1:0] dev_wdata_o
);
    always_comb begin
        mem_rd_o    = active_i && !to_mem_i;
        dev_wr_o    = active_i && !to_mem_i;
        dev_rd_o    = active_i && to_mem_i;
        mem_wr_o    = active_i && to_mem_i;
        mem_wdata_o = dev_rdata_i;
        dev_wdata_o = mem_rdata_i;
    end
endmodule

// File: rtl/blk_dma_seq.sv
module blk_dma_seq
    import blk_dma_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                BASE_W    = 24,
    parameter int                DATA_W    = 32,
    parameter int                CNT_W     = 16,
    parameter logic [ADDR_W-1:0] MEM_MASK  = 32'h001F_FFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic [CNT_W-1:0]  cfg_blk_size,
    input  logic [CNT_W-1:0]  cfg_blk_count,
    input  logic              cfg_to_mem,
    input  logic              cfg_step_down,
    input  logic              cfg_enable,
    input  logic              cfg_trigger,
    input  logic              dev_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              dev_rd,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              dev_wr,
    output logic [DATA_W-1:0] dev_wdata,
    output logic [BASE_W-1:0] st_base,
    output logic [CNT_W-1:0]  st_count,
    output logic              st_enable,
    output logic              st_trigger,
    output logic              busy,
    output logic              done
);
    localparam int               EXT_W   = ADDR_W - BASE_W;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        phase_e              phase;
        logic [BASE_W-1:0]   base;
        logic [CNT_W-1:0]    size;
        logic [CNT_W-1:0]    count;
        logic                to_mem;
        logic                step_down;
        logic                enable;
        logic                trigger;
        logic [ADDR_W-1:0]   ptr;
        logic [CNT_W-1:0]    widx;
        logic                done;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [ADDR_W-1:0] ptr_next;
    logic              block_last;

    // address stepping and masking
    blk_dma_addr #(
        .ADDR_W   (ADDR_W),
        .MEM_MASK (MEM_MASK)
    ) u_addr (
        .ptr_i       (st_q.ptr),
        .step_down_i (st_q.step_down),
        .ptr_next_o  (ptr_next),
        .mem_addr_o  (mem_addr)
    );

    // strobe and data routing by direction
    blk_dma_route #(
        .DATA_W (DATA_W)
    ) u_route (
        .active_i    (busy),
        .to_mem_i    (st_q.to_mem),
        .mem_rdata_i (mem_rdata),
        .dev_rdata_i (dev_rdata),
        .mem_rd_o    (mem_rd),
        .mem_wr_o    (mem_wr),
        .mem_wdata_o (mem_wdata),
        .dev_rd_o    (dev_rd),
        .dev_wr_o    (dev_wr),
        .dev_wdata_o (dev_wdata)
    );

    assign block_last = (st_q.widx == (st_q.size - CNT_ONE));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (cfg_we) begin
                    st_d.base      = cfg_base;
                    st_d.size      = cfg_blk_size;
                    st_d.count     = cfg_blk_count;
                    st_d.to_mem    = cfg_to_mem;
                    st_d.step_down = cfg_step_down;
                    st_d.enable    = cfg_enable;
                    st_d.trigger   = cfg_trigger;
                end else if (st_q.enable) begin
                    if (st_q.count == '0) begin
                        st_d.done   = 1'b1;
                        st_d.enable = 1'b0;
                    end else if (dev_req) begin
                        st_d.phase   = PH_XFER;
                        st_d.trigger = 1'b0;
                        st_d.count   = st_q.count - CNT_ONE;
                        st_d.ptr     = {{EXT_W{1'b0}}, st_q.base};
                        st_d.widx    = '0;
                    end
                end
            end
            PH_XFER: begin
                st_d.ptr  = ptr_next;
                st_d.widx = st_q.widx + CNT_ONE;
                if (block_last) begin
                    st_d.widx = '0;
                    if (dev_req && (st_q.count != '0)) begin
                        st_d.count = st_q.count - CNT_ONE;
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.base  = ptr_next[BASE_W-1:0];
                        if (st_q.count == '0) begin
                            st_d.done   = 1'b1;
                            st_d.enable = 1'b0;
                        end
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = (st_q.phase == PH_XFER);
    assign done       = st_q.done;
    assign st_base    = st_q.base;
    assign st_count   = st_q.count;
    assign st_enable  = st_q.enable;
    assign st_trigger = st_q.trigger;
endmodule

// File: rtl/blk_dma_seq_chk.sv
module blk_dma_seq_chk #(
    parameter int                ADDR_W   = 32,
    parameter int                CNT_W    = 16,
    parameter logic [ADDR_W-1:0] MEM_MASK = 32'h001F_FFFC
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              enable,
    input logic              trigger,
    input logic [CNT_W-1:0]  count,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              dev_rd,
    input logic              dev_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              step_down
);
    logic acc;
    assign acc = mem_rd || mem_wr;

    // R4: exclusive roles on each side
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr) && !(dev_rd && dev_wr));

    // R4: accesses only while a transfer runs
    a_r4_access_busy: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> busy);

    // R5: consecutive accesses are four bytes apart after masking
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && busy && $past(acc) && $past(busy)) |->
        (mem_addr == ((step_down ? ($past(mem_addr) - ADDR_W'(4))
                                 : ($past(mem_addr) + ADDR_W'(4))) & MEM_MASK)));

    // R6: the count never rises across a busy cycle
    a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (count <= $past(count)));

    // R3: start flag is clear once a transfer begins
    a_r3_trig_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !trigger);

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done comes with enable cleared and the channel idle
    a_r9_done_disables: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!enable && !busy));
endmodule

bind blk_dma_seq blk_dma_seq_chk #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .MEM_MASK (MEM_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .enable    (st_enable),
    .trigger   (st_trigger),
    .count     (st_count),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .dev_rd    (dev_rd),
    .dev_wr    (dev_wr),
    .mem_addr  (mem_addr),
    .step_down (st_q.step_down)
);

// File: tb/blk_dma_seq_tb.sv
`timescale 1ns/1ps
module blk_dma_seq_tb;
    localparam logic [31:0] MASK_MEM  = 32'h001F_FFFC;
    localparam logic [31:0] MASK_BASE = 32'h00FF_FFFF;
    localparam int          LOG_N     = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [23:0] cfg_base = '0;
    logic [15:0] cfg_blk_size = '0;
    logic [15:0] cfg_blk_count = '0;
    logic        cfg_to_mem = 1'b0;
    logic        cfg_step_down = 1'b0;
    logic        cfg_enable = 1'b0;
    logic        cfg_trigger = 1'b0;
    logic        req_drv = 1'b0;
    int          pause_at = 0;
    int          pause_n0 = 0;
    logic        dev_req;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, dev_rdata, dev_wdata;
    logic        mem_rd, mem_wr, dev_rd, dev_wr;
    logic [23:0] st_base;
    logic [15:0] st_count;
    logic        st_enable, st_trigger, busy, done;

    int          total = 0;
    int          bad = 0;
    int          n = 0;
    int          done_cnt = 0;
    int          pop = 0;
    logic [31:0] log_addr [LOG_N];
    logic [31:0] log_data [LOG_N];
    logic        log_wr   [LOG_N];
    logic        log_role [LOG_N];
    logic [31:0] bmem [64];

    always #2 clk = ~clk;

    assign dev_req   = req_drv && !((pause_at != 0) && ((n - pause_n0) >= pause_at));
    assign mem_rdata = bmem[mem_addr[7:2]];
    assign dev_rdata = 32'hD000_0000 + 32'(pop);

    blk_dma_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base),
        .cfg_blk_size(cfg_blk_size), .cfg_blk_count(cfg_blk_count),
        .cfg_to_mem(cfg_to_mem), .cfg_step_down(cfg_step_down),
        .cfg_enable(cfg_enable), .cfg_trigger(cfg_trigger), .dev_req(dev_req),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_rd(dev_rd),
        .dev_rdata(dev_rdata), .dev_wr(dev_wr), .dev_wdata(dev_wdata),
        .st_base(st_base), .st_count(st_count), .st_enable(st_enable),
        .st_trigger(st_trigger), .busy(busy), .done(done)
    );

    // memory and device models
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) bmem[i] <= 32'h1000_0000 | 32'(i);
        end else if (mem_wr) begin
            bmem[mem_addr[7:2]] <= mem_wdata;
        end
        if (rst_n && dev_rd) pop <= pop + 1;
    end

    // access monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if ((mem_rd || mem_wr) && n < LOG_N) begin
                log_addr[n] = mem_addr;
                log_data[n] = mem_wr ? mem_wdata : dev_wdata;
                log_wr[n]   = mem_wr;
                log_role[n] = mem_wr ? (dev_rd && !dev_wr && !mem_rd)
                                     : (mem_rd && dev_wr && !dev_rd);
                n = n + 1;
            end
            if (done) done_cnt = done_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [23:0] b, input int s, input int c, input bit tm,
                        input bit dn, input bit en, input bit tg);
        @(negedge clk);
        cfg_base = b; cfg_blk_size = 16'(s); cfg_blk_count = 16'(c);
        cfg_to_mem = tm; cfg_step_down = dn; cfg_enable = en; cfg_trigger = tg;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_stop();
        int t;
        t = 0;
        while (!busy && t < 100) begin @(negedge clk); t++; end
        if (t >= 100) check(1'b0, "R3 start timeout", 32'(busy), 32'd1);
        t = 0;
        while (busy && t < 5000) begin @(negedge clk); t++; end
        if (t >= 5000) check(1'b0, "R6 stop timeout", 32'(busy), 32'd0);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [31:0] walk(input logic [23:0] b, input bit dn, input int k);
        return dn ? ({8'h00, b} - 32'(4 * k)) : ({8'h00, b} + 32'(4 * k));
    endfunction

    // check words n0 .. n0+cnt-1 of a run that began at b
    task automatic check_words(input int n0, input int cnt, input logic [23:0] b,
                               input bit tm, input bit dn, input int p0);
        logic [31:0] ea, ex;
        for (int k = 0; k < cnt; k++) begin
            ea = walk(b, dn, k) & MASK_MEM;
            ex = tm ? (32'hD000_0000 + 32'(p0 + k)) : bmem[ea[7:2]];
            check(log_addr[n0 + k] == ea, "R5 word address", log_addr[n0 + k], ea);
            check(log_wr[n0 + k] == tm, "R4 direction", 32'(log_wr[n0 + k]), 32'(tm));
            check(log_role[n0 + k], "R4 strobes", 32'(log_role[n0 + k]), 32'd1);
            check(log_data[n0 + k] == ex, "R4 data", log_data[n0 + k], ex);
        end
    endtask

    task automatic run_full(input logic [23:0] b, input int s, input int c,
                            input bit tm, input bit dn);
        int n0, p0, d0;
        logic [31:0] eb;
        n0 = n; p0 = pop; d0 = done_cnt;
        load(b, s, c, tm, dn, 1'b1, 1'b1);
        req_drv = 1'b1;
        wait_stop();
        req_drv = 1'b0;
        check((n - n0) == s * c, "R6 words moved", 32'(n - n0), 32'(s * c));
        check_words(n0, s * c, b, tm, dn, p0);
        eb = walk(b, dn, s * c) & MASK_BASE;
        check({8'h00, st_base} == eb, "R7 stored base", {8'h00, st_base}, eb);
        check(st_count == 16'd0, "R7 stored count", 32'(st_count), 32'd0);
        check(!st_enable, "R9 enable cleared", 32'(st_enable), 32'd0);
        check(done_cnt - d0 == 1, "R9 one done pulse", 32'(done_cnt - d0), 32'd1);
        check(!st_trigger, "R3 start flag", 32'(st_trigger), 32'd0);
    endtask

    initial begin : watchdog
        #800000;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

    initial begin : main
        int n0, p0, d0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !st_enable && !st_trigger, "R1 reset flags",
              {28'h0, busy, done, st_enable, st_trigger}, 32'd0);
        check(st_base == 24'd0 && st_count == 16'd0, "R1 reset fields",
              {st_base[15:0], st_count}, 32'd0);
        check(!mem_rd && !mem_wr && !dev_rd && !dev_wr, "R1 no strobes",
              {28'h0, mem_rd, mem_wr, dev_rd, dev_wr}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!st_enable && !busy, "R1 after release", {30'h0, st_enable, busy}, 32'd0);

        // sweep over direction, step, block size and count (R4 R5 R6 R7 R9)
        for (int tm = 0; tm < 2; tm++)
            for (int dn = 0; dn < 2; dn++)
                for (int s = 1; s <= 3; s++)
                    for (int c = 1; c <= 3; c++)
                        run_full(dn ? 24'h000008 : (24'hE00040 + 24'(s * 8)), s, c,
                                 bit'(tm), bit'(dn));

        // R3: disabled channel ignores the request
        n0 = n;
        load(24'h000100, 2, 2, 1'b0, 1'b0, 1'b0, 1'b0);
        req_drv = 1'b1;
        repeat (10) @(negedge clk);
        req_drv = 1'b0;
        check(n == n0 && !busy, "R3 disabled no access", 32'(n - n0), 32'd0);

        // R3: start flag holds until the transfer begins
        n0 = n; p0 = pop;
        load(24'h000180, 2, 2, 1'b1, 1'b0, 1'b1, 1'b1);
        repeat (5) @(negedge clk);
        check(st_trigger && !busy && n == n0, "R3 waits for request",
              {30'h0, st_trigger, busy}, 32'd2);
        req_drv = 1'b1;
        while (!busy) @(negedge clk);
        check(!st_trigger, "R3 flag cleared at start", 32'(st_trigger), 32'd0);
        wait_stop();
        req_drv = 1'b0;
        check_words(n0, 4, 24'h000180, 1'b1, 1'b0, p0);

        // R8 and R6: pause inside block 2, sampled only at its end
        n0 = n; d0 = done_cnt;
        load(24'h000100, 3, 3, 1'b0, 1'b0, 1'b1, 1'b0);
        pause_n0 = n; pause_at = 4;
        req_drv = 1'b1;
        wait_stop();
        check((n - n0) == 6, "R6 boundary sampling", 32'(n - n0), 32'd6);
        check(st_count == 16'd1, "R8 paused count", 32'(st_count), 32'd1);
        check(st_base == 24'h000118, "R8 paused base", 32'(st_base), 32'h118);
        check(st_enable && done_cnt == d0, "R8 still enabled, no done",
              {31'h0, st_enable}, 32'd1);
        req_drv = 1'b0;
        pause_at = 0;
        repeat (8) @(negedge clk);
        check((n - n0) == 6 && !busy, "R3 no resume without request", 32'(n - n0), 32'd6);
        req_drv = 1'b1;
        wait_stop();
        req_drv = 1'b0;
        check((n - n0) == 9, "R8 resumed words", 32'(n - n0), 32'd9);
        check_words(n0, 9, 24'h000100, 1'b0, 1'b0, 0);
        check(st_base == 24'h000124 && st_count == 16'd0, "R8 final state",
              {8'h0, st_base}, 32'h124);
        check(!st_enable && done_cnt - d0 == 1, "R9 done after resume",
              32'(done_cnt - d0), 32'd1);

        // R2: load while busy is ignored
        n0 = n; p0 = pop;
        load(24'h000200, 3, 3, 1'b1, 1'b0, 1'b1, 1'b0);
        req_drv = 1'b1;
        while (!busy) @(negedge clk);
        load(24'h000040, 1, 7, 1'b0, 1'b1, 1'b0, 1'b1);
        wait_stop();
        req_drv = 1'b0;
        check((n - n0) == 9, "R2 words unchanged", 32'(n - n0), 32'd9);
        check(st_base == 24'h000224, "R2 base unchanged", 32'(st_base), 32'h224);
        check(!st_trigger && st_count == 16'd0, "R2 fields unchanged",
              {15'h0, st_trigger, st_count}, 32'd0);
        check_words(n0, 9, 24'h000200, 1'b1, 1'b0, p0);

        // R9: enabled with zero count
        n0 = n; d0 = done_cnt;
        load(24'h000300, 2, 0, 1'b0, 1'b0, 1'b1, 1'b0);
        req_drv = 1'b1;
        repeat (6) @(negedge clk);
        req_drv = 1'b0;
        check(done_cnt - d0 == 1, "R9 zero count done", 32'(done_cnt - d0), 32'd1);
        check(!st_enable && n == n0, "R9 zero count no access",
              {31'h0, st_enable}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule